// File: doc/BRIEF.md
# Triangular Spread-Spectrum Sweep Controller

This block sequences a symmetric triangular frequency sweep for an all-digital clock generator. On each modulation tick it presents a direction flag and a step magnitude, which a downstream code generator adds to or subtracts from the oscillator control word. The sweep starts at the stored center, climbs for a quarter period, falls through the center for a half period to the opposite peak, and climbs back for a quarter period. The control word therefore spends equal time above and below the center.

The depth and slope come from two 3-bit settings. A section setting fixes how many ticks make up a half period. A step setting fixes the size of each increment. Their product sets the peak excursion, so one spreading ratio (for example 1 %) can be reached with either a slow, fine ramp or a fast, coarse one. A mode input turns spreading on and off. When spreading is off, the block emits zero steps, so the control word stays where it is. Each time spreading is turned on, the profile starts again from the center.

Top module: `tri_spread_mod`

## Requirements
- R1: While `spread_en` is low, every tick cycle loads `step_out` = 0 and `dir_sub` = 0.
- R2: While spreading, `step_out` = 2^`step_sel` (one-hot, `step_sel` 0..7 giving 1..128).
- R3: `step_out` and `dir_sub` change only in the clock after a cycle with `tick_en` high.
- R4: With half-period H = 2^(`sec_sel`+4) ticks and quarter Q = H/2, the direction sequence is Q ticks add (`dir_sub`=0), then H ticks subtract (`dir_sub`=1), then Q ticks add. The sequence then repeats with period 2H.
- R5: The first tick after `spread_en` rises is an add tick at profile index 0.
- R6: Over one full period the signed sum of steps is zero. The running sum peaks at +Q·step and reaches a minimum of −Q·step.
- R7: `sec_sel` and `step_sel` are captured only on clocks where `spread_en` is low. Changes made while spreading have no effect on the outputs.
- R8: A tick in a cycle where `spread_en` drops loads a zero step. A later enable restarts the profile at index 0.
- R9: After reset, `step_out` = 0 and `dir_sub` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | 1 = spread-spectrum mode, 0 = hold control word |
| tick_en | input | 1 | Modulation tick; outputs update only after tick cycles |
| sec_sel | input | 3 | Section setting; half period = 2^(sec_sel+4) ticks |
| step_sel | input | 3 | Step setting; step = 2^step_sel LSBs |
| dir_sub | output | 1 | 1 = subtract step, 0 = add step |
| step_out | output | 16 | Step magnitude for this tick |

## Verification
Two events can fall in the same cycle: a modulation tick and the drop of `spread_en`. If they coincide at a profile peak, one source of error is a final nonzero step; another is a counter that survives into the next enable. The bench provokes this by dropping the enable on the very tick that reaches the upper peak. It then judges that tick's step to be zero. After re-enabling, it judges that the first tick adds and that the whole next period keeps the exact triangular order and nets to zero.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int SEL_W      = 3;
  localparam int STEP_W     = 16;
  localparam int BASE_EXP   = 4;
  localparam int CNT_W      = (1 << SEL_W) - 1 + BASE_EXP + 1;

  typedef struct packed {
    logic [SEL_W-1:0] sec;
    logic [SEL_W-1:0] step;
  } tsm_cfg_t;
endpackage

// File: rtl/tsm_step_decode.sv
module tsm_step_decode #(
  parameter int SEL_W  = 3,
  parameter int STEP_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [STEP_W-1:0] step
);
  localparam int NCODES = 1 << SEL_W;

  for (genvar i = 0; i < STEP_W; i++) begin : g_bit
    if (i < NCODES) begin : g_live
      assign step[i] = (sel == SEL_W'(i));
    end else begin : g_zero
      assign step[i] = 1'b0;
    end
  end
endmodule

// File: rtl/tsm_phase_counter.sv
module tsm_phase_counter #(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 4,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [SEL_W-1:0] sec,
  output logic             sub
);
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] wrap_mask, quarter, three_q;

  always_comb begin
    wrap_mask = CNT_W'((1 << (int'(sec) + BASE_EXP + 1)) - 1);
    quarter   = CNT_W'(1 << (int'(sec) + BASE_EXP - 1));
    three_q   = CNT_W'(3) * quarter;
    sub       = (idx_q >= quarter) && (idx_q < three_q);
  end

  always_comb begin
    idx_d = idx_q;
    if (!run)     idx_d = '0;
    else if (adv) idx_d = (idx_q + CNT_W'(1)) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/tri_spread_mod.sv
module tri_spread_mod
  import tsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic              tick_en,
  input  logic [SEL_W-1:0]  sec_sel,
  input  logic [SEL_W-1:0]  step_sel,
  output logic              dir_sub,
  output logic [STEP_W-1:0] step_out
);
  tsm_cfg_t          cfg_q, cfg_d;
  logic              ph_sub;
  logic [STEP_W-1:0] dec_step;
  logic              dir_d;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    cfg_d = cfg_q;
    if (!spread_en) begin
      cfg_d.sec  = sec_sel;
      cfg_d.step = step_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  tsm_phase_counter #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .run(spread_en), .adv(tick_en),
    .sec(cfg_q.sec), .sub(ph_sub)
  );

  tsm_step_decode #(.SEL_W(SEL_W), .STEP_W(STEP_W)) u_dec (
    .sel(cfg_q.step), .step(dec_step)
  );

  always_comb begin
    dir_d  = dir_sub;
    step_d = step_out;
    if (tick_en) begin
      dir_d  = spread_en ? ph_sub   : 1'b0;
      step_d = spread_en ? dec_step : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_sub  <= 1'b0;
      step_out <= '0;
    end else begin
      dir_sub  <= dir_d;
      step_out <= step_d;
    end
  end
endmodule

// File: rtl/tri_spread_mod_chk.sv
module tri_spread_mod_chk
  import tsm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              spread_en,
  input logic              tick_en,
  input logic              dir_sub,
  input logic [STEP_W-1:0] step_out
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !spread_en) |=> (step_out == '0 && !dir_sub)); // R1

  AST_ONEHOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_out)); // R2

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(step_out) && $stable(dir_sub))); // R3

  AST_START_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spread_en) && tick_en) |=> (!dir_sub && step_out != '0)); // R5
endmodule

bind tri_spread_mod tri_spread_mod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .tick_en(tick_en),
  .dir_sub(dir_sub), .step_out(step_out)
);

// File: tb/sim_tri_spread_mod.sv
module sim_tri_spread_mod;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        spread_en;
  logic        tick_en;
  logic [2:0]  sec_sel;
  logic [2:0]  step_sel;
  logic        dir_sub;
  logic [15:0] step_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tri_spread_mod u0 (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .tick_en(tick_en),
    .sec_sel(sec_sel), .step_sel(step_sel), .dir_sub(dir_sub), .step_out(step_out)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge; sample at the following negedge
  task automatic cyc(input bit tk);
    tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic setup(input int s, input int st);
    spread_en = 1'b0; sec_sel = 3'(s); step_sel = 3'(st);
    cyc(1'b0);
    cyc(1'b0);
  endtask

  function automatic bit exp_sub(input int s, input int i);
    int q = 1 << (s + 3);
    int k = i % (4 * q);
    return (k >= q) && (k < 3 * q);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; spread_en = 1'b0; tick_en = 1'b0; sec_sel = '0; step_sel = '0;
    repeat (3) @(negedge clk);
    check("R9 step", step_out, 0);
    check("R9 dir", dir_sub, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle();
    setup(1, 5);
    for (int i = 0; i < 8; i++) cyc(1'b1);
    check("R1 step idle", step_out, 0);
    check("R1 dir idle", dir_sub, 0);
  endtask

  // full period profile: direction order, step size, peaks, net zero
  task automatic t_profile(input int s, input int st);
    int q = 1 << (s + 3);
    int bad_dir = 0, bad_step = 0;
    longint acc = 0, mx = 0, mn = 0;
    setup(s, st);
    spread_en = 1'b1;
    for (int i = 0; i < 4 * q; i++) begin
      cyc(1'b1);
      if (dir_sub !== exp_sub(s, i)) bad_dir++;
      if (step_out !== 16'(1 << st)) bad_step++;
      acc += dir_sub ? -longint'(step_out) : longint'(step_out);
      if (acc > mx) mx = acc;
      if (acc < mn) mn = acc;
    end
    check("R4 direction mismatches", bad_dir, 0);
    check("R2 step mismatches", bad_step, 0);
    check("R6 net", acc, 0);
    check("R6 peak", mx, longint'(q) << st);
    check("R6 trough", mn, -(longint'(q) << st));
    spread_en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_hold();
    logic [15:0] s0;
    logic        d0;
    setup(0, 2);
    spread_en = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b1);
    s0 = step_out; d0 = dir_sub;
    cyc(1'b1);                       // index 8 -> subtract
    check("R3 ticked dir", dir_sub, 1);
    for (int i = 0; i < 5; i++) cyc(1'b0);
    check("R3 held dir", dir_sub, 1);
    check("R3 held step", step_out, 4);
    check("R3 prior dir", d0, 0);
    check("R3 prior step", s0, 4);
    spread_en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_cfg_ignored();
    int bad = 0;
    setup(0, 1);
    spread_en = 1'b1;
    cyc(1'b1);
    sec_sel = 3'd7; step_sel = 3'd6;
    for (int i = 1; i < 32; i++) begin
      cyc(1'b1);
      if (step_out !== 16'd2 || dir_sub !== exp_sub(0, i)) bad++;
    end
    check("R7 config ignored while spreading", bad, 0);
    spread_en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_disable_on_peak();
    int bad = 0;
    longint acc = 0;
    setup(0, 0);
    spread_en = 1'b1;
    for (int i = 0; i < 7; i++) cyc(1'b1);
    spread_en = 1'b0;
    cyc(1'b1);                       // tick 7 would be the last rise
    check("R8 zero step at drop", step_out, 0);
    cyc(1'b0);
    spread_en = 1'b1;
    cyc(1'b1);
    check("R5 restart adds", dir_sub, 0);
    check("R5 restart step", step_out, 1);
    acc = 1;
    for (int i = 1; i < 32; i++) begin
      cyc(1'b1);
      if (dir_sub !== exp_sub(0, i)) bad++;
      acc += dir_sub ? -1 : 1;
    end
    check("R8 restarted order", bad, 0);
    check("R8 restarted net", acc, 0);
    spread_en = 1'b0;
    cyc(1'b1);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_profile(0, 0);
    t_profile(2, 7);
    t_profile(7, 3);
    t_hold();
    t_cfg_ignored();
    t_disable_on_peak();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule